// File: doc/BRIEF.md
# TLB Maintenance Command Decoder

This block watches a register write port and turns writes to a small set of maintenance indices into translation-cache invalidation commands. Two command channels leave the block, one feeding the instruction-side TLB and one feeding the data-side TLB. Each channel carries a one-cycle valid strobe together with an operation code, a page number and an address-space identifier.

The register index picks the operation and the target side or sides. The page number and identifier are sliced from the write data. A maintenance write is consumed entirely as a command, so it never updates any stored register. Writes to every other index produce no command.

Top module: `tlbMaintDecoder`

## Requirements
- R1: After reset both command valid outputs (iCmdValid, dCmdValid) are low.
- R2: The operation code is 2 bits: 0 invalidates all entries, 1 invalidates by page and ASID, 2 invalidates by ASID only, and 3 invalidates by page for any ASID.
- R3: Unified indices (0 all, 1 page+ASID, 2 ASID, 3 page-any-ASID) drive the same command on both channels.
- R4: Inner-shareable indices (4 all, 5 page+ASID, 6 ASID, 7 page-any-ASID) behave exactly like indices 0 to 3.
- R5: Instruction-only indices (8 all, 9 page+ASID, 10 ASID) drive only the instruction channel. Data-only indices (12 all, 13 page+ASID, 14 ASID) drive only the data channel.
- R6: For page-based operations the page output equals write data bits 31:12. For ASID-based operations the ASID output equals write data bits 7:0. Unused operand fields are driven to zero.
- R7: A valid strobe rises exactly one clock after the accepted write and lasts a single cycle unless another maintenance write follows.
- R8: A write to any index not listed in R3 to R5 (for example 11, 15, or 16 and above) raises no valid strobe. A cycle with the write enable low raises none either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write enable |
| regIdx | input | 6 | Register index being written |
| regWrData | input | 32 | Write data |
| iCmdValid | output | 1 | Instruction TLB command strobe |
| iCmdOp | output | 2 | Instruction TLB operation |
| iCmdPage | output | 20 | Instruction TLB page number |
| iCmdAsid | output | 8 | Instruction TLB ASID |
| dCmdValid | output | 1 | Data TLB command strobe |
| dCmdOp | output | 2 | Data TLB operation |
| dCmdPage | output | 20 | Data TLB page number |
| dCmdAsid | output | 8 | Data TLB ASID |

## Verification
The bench sweeps every index in the 6-bit space with data patterns whose page and ASID bits differ, so operand slicing and zeroing are both observable. It looks for three kinds of fault. Swapping the instruction-only and data-only targets would light the wrong channel. Dropping the inner-shareable aliases would silence indices 4 to 7. Decoding the holes 11 and 15 would produce spurious strobes. Back-to-back and enable-low writes check that the strobe stays a single pulse and that a command appears only for an accepted write.

// File: rtl/tlbMaintPkg.sv
package tlbMaintPkg;
  localparam int IdxW   = 6;
  localparam int DataW  = 32;
  localparam int PageLo = 12;
  localparam int PageW  = DataW - PageLo;
  localparam int AsidW  = 8;

  typedef enum logic [1:0] {
    OP_ALL       = 2'd0,
    OP_PAGE_ASID = 2'd1,
    OP_ASID      = 2'd2,
    OP_PAGE_ANY  = 2'd3
  } tlbOpE;

  typedef struct packed {
    logic  hitI;
    logic  hitD;
    logic  usePage;
    logic  useAsid;
    tlbOpE op;
  } decStrobeS;
endpackage

// File: rtl/tlbMaintCtrl.sv
module tlbMaintCtrl
  import tlbMaintPkg::*;
(
  input  logic            regWrEn,
  input  logic [IdxW-1:0] regIdx,
  output decStrobeS       strobe
);
  logic [1:0] grp;
  logic [1:0] low;
  logic       inRange;

  assign grp     = regIdx[3:2];
  assign low     = regIdx[1:0];
  assign inRange = (regIdx[IdxW-1:4] == '0);

  always_comb begin
    strobe = '{hitI: 1'b0, hitD: 1'b0, usePage: 1'b0, useAsid: 1'b0, op: OP_ALL};
    strobe.op = tlbOpE'(low);
    if (regWrEn && inRange) begin
      unique case (grp)
        2'd0, 2'd1: begin
          strobe.hitI = 1'b1;
          strobe.hitD = 1'b1;
        end
        2'd2: strobe.hitI = (low != 2'd3);
        2'd3: strobe.hitD = (low != 2'd3);
        default: ;
      endcase
    end
    strobe.usePage = (low == 2'd1) || (low == 2'd3);
    strobe.useAsid = (low == 2'd1) || (low == 2'd2);
  end
endmodule

// File: rtl/tlbMaintPath.sv
module tlbMaintPath
  import tlbMaintPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  decStrobeS        strobe,
  input  logic [DataW-1:0] regWrData,
  output logic             iCmdValid,
  output logic             dCmdValid,
  output logic [1:0]       cmdOp,
  output logic [PageW-1:0] cmdPage,
  output logic [AsidW-1:0] cmdAsid
);
  logic [PageW-1:0] pageNext;
  logic [AsidW-1:0] asidNext;

  assign pageNext = strobe.usePage ? regWrData[DataW-1:PageLo] : '0;
  assign asidNext = strobe.useAsid ? regWrData[AsidW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iCmdValid <= 1'b0;
      dCmdValid <= 1'b0;
      cmdOp     <= '0;
      cmdPage   <= '0;
      cmdAsid   <= '0;
    end else begin
      iCmdValid <= strobe.hitI;
      dCmdValid <= strobe.hitD;
      if (strobe.hitI || strobe.hitD) begin
        cmdOp   <= strobe.op;
        cmdPage <= pageNext;
        cmdAsid <= asidNext;
      end
    end
  end
endmodule

// File: rtl/tlbMaintDecoder.sv
module tlbMaintDecoder
  import tlbMaintPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [5:0]   regIdx,
  input  logic [31:0]  regWrData,
  output logic         iCmdValid,
  output logic [1:0]   iCmdOp,
  output logic [19:0]  iCmdPage,
  output logic [7:0]   iCmdAsid,
  output logic         dCmdValid,
  output logic [1:0]   dCmdOp,
  output logic [19:0]  dCmdPage,
  output logic [7:0]   dCmdAsid
);
  decStrobeS        strobe;
  logic [1:0]       cmdOp;
  logic [PageW-1:0] cmdPage;
  logic [AsidW-1:0] cmdAsid;

  tlbMaintCtrl i_ctrl (
    .regWrEn(regWrEn), .regIdx(regIdx), .strobe(strobe)
  );

  tlbMaintPath i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .iCmdValid(iCmdValid), .dCmdValid(dCmdValid),
    .cmdOp(cmdOp), .cmdPage(cmdPage), .cmdAsid(cmdAsid)
  );

  assign iCmdOp   = cmdOp;
  assign iCmdPage = cmdPage;
  assign iCmdAsid = cmdAsid;
  assign dCmdOp   = cmdOp;
  assign dCmdPage = cmdPage;
  assign dCmdAsid = cmdAsid;
endmodule

// File: rtl/tlbMaintChecker.sv
module tlbMaintChecker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [5:0]  regIdx,
  input logic [31:0] regWrData,
  input logic        iCmdValid,
  input logic [1:0]  iCmdOp,
  input logic [19:0] iCmdPage,
  input logic [7:0]  iCmdAsid,
  input logic        dCmdValid,
  input logic [1:0]  dCmdOp
);
  logic pastOk;
  always_ff @(posedge clk) pastOk <= rstN;

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !iCmdValid && !dCmdValid); // R1
  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !regWrEn |=> !iCmdValid && !dCmdValid); // R8
  AST_HOLE_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && regWrEn && (regIdx == 6'd11 || regIdx == 6'd15 || regIdx >= 6'd16)
    |=> !iCmdValid && !dCmdValid); // R8
  AST_UNIFIED_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && regWrEn && regIdx < 6'd8 |=> iCmdValid && dCmdValid && iCmdOp == dCmdOp); // R3
  AST_ALIAS_OP: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && regWrEn && regIdx < 6'd8 |=> iCmdOp == $past(regIdx[1:0])); // R4
  AST_PAGE_SLICE: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && regWrEn && regIdx[3:0] == 4'd9 && regIdx[5:4] == 2'd0
    |=> iCmdPage == $past(regWrData[31:12]) && iCmdAsid == $past(regWrData[7:0])); // R6
  AST_SIDE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && regWrEn && regIdx >= 6'd8 && regIdx <= 6'd10 |=> iCmdValid && !dCmdValid); // R5
endmodule

bind tlbMaintDecoder tlbMaintChecker i_checker (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx), .regWrData(regWrData),
  .iCmdValid(iCmdValid), .iCmdOp(iCmdOp), .iCmdPage(iCmdPage), .iCmdAsid(iCmdAsid),
  .dCmdValid(dCmdValid), .dCmdOp(dCmdOp)
);

// File: tb/test_tlbMaintDecoder.sv
module test_tlbMaintDecoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regIdx = '0;
  logic [31:0] regWrData = '0;
  logic        iCmdValid, dCmdValid;
  logic [1:0]  iCmdOp, dCmdOp;
  logic [19:0] iCmdPage, dCmdPage;
  logic [7:0]  iCmdAsid, dCmdAsid;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tlbMaintDecoder i_tlbMaintDecoder (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model: returns {hitI, hitD, op, page, asid}
  task automatic model(input logic [5:0] idx, input logic [31:0] d,
                       output logic hi, output logic hd, output logic [1:0] op,
                       output logic [19:0] pg, output logic [7:0] as);
    hi = 0; hd = 0; op = idx[1:0];
    if (idx < 8) begin hi = 1; hd = 1; end
    else if (idx >= 8 && idx <= 10) hi = 1;
    else if (idx >= 12 && idx <= 14) hd = 1;
    pg = (op == 1 || op == 3) ? d[31:12] : 20'h0;
    as = (op == 1 || op == 2) ? d[7:0] : 8'h0;
  endtask

  task automatic doWrite(input logic [5:0] idx, input logic [31:0] d);
    logic hi, hd; logic [1:0] op; logic [19:0] pg; logic [7:0] as;
    model(idx, d, hi, hd, op, pg, as);
    @(negedge clk);
    regWrEn = 1; regIdx = idx; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
    chk("R5/R3/R8 iValid", 64'(iCmdValid), 64'(hi));
    chk("R5/R3/R8 dValid", 64'(dCmdValid), 64'(hd));
    if (hi || hd) begin
      chk("R2/R4 op", 64'(hi ? iCmdOp : dCmdOp), 64'(op));
      chk("R6 page", 64'(hi ? iCmdPage : dCmdPage), 64'(pg));
      chk("R6 asid", 64'(hi ? iCmdAsid : dCmdAsid), 64'(as));
      if (hi && hd) chk("R3 same cmd", 64'({dCmdOp, dCmdPage, dCmdAsid}), 64'({iCmdOp, iCmdPage, iCmdAsid}));
    end
    @(negedge clk);
    chk("R7 single pulse", 64'({iCmdValid, dCmdValid}), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 64'({iCmdValid, dCmdValid}), 64'(0));
    rstN = 1;
    for (int idx = 0; idx < 64; idx++) begin
      doWrite(6'(idx), 32'hABCDE5A7 ^ (32'(idx) * 32'h01010101));
      doWrite(6'(idx), 32'h12345F0C);
    end
    // R8: enable low with a maintenance index
    @(negedge clk); regWrEn = 0; regIdx = 6'd0; regWrData = '1;
    @(negedge clk);
    chk("R8 enable low", 64'({iCmdValid, dCmdValid}), 64'(0));
    // R7: back-to-back writes, strobes on consecutive cycles
    @(negedge clk); regWrEn = 1; regIdx = 6'd9; regWrData = 32'hFFFFF011;
    @(negedge clk); regIdx = 6'd13; regWrData = 32'h00001022;
    chk("R7 first", 64'({iCmdValid, dCmdValid, iCmdAsid}), 64'({2'b10, 8'h11}));
    @(negedge clk); regWrEn = 0;
    chk("R7 second", 64'({iCmdValid, dCmdValid, dCmdAsid}), 64'({2'b01, 8'h22}));
    @(negedge clk);
    chk("R7 end", 64'({iCmdValid, dCmdValid}), 64'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule